// File: doc/BRIEF.md
# Serial Configuration Port with Transfer Abort

This block is a slave serial port through which a host loads and reads back a small bank of 8-bit configuration registers. A transfer opens when the active-low select goes low. The host first shifts in one instruction byte, most significant bit first. That byte carries a read/write flag and a register address. The host then shifts any number of data bytes in or out, and the address steps up by one after each byte. Several slaves can share the clock and data lines, because each one answers only while its own select is low.

All port inputs are oversampled in the system clock domain through two-stage synchronizers, and edges of the serial clock are found there. Each phase of the serial clock, and the select setup before the first rising edge, must last at least 6 system clock cycles.

Bit 7 of register 0 chooses the readback pin:
- When the bit is clear (the default), read data leaves on the bidirectional data pin, which the port drives only during the read data phase.
- When the bit is set, the data pin is input only, and read data leaves on a separate output pin that is otherwise in high impedance.

An active-high sync input cancels the transfer in progress and leaves every register as it was. A second, parallel read port lets the surrounding core read the registers.

Top module: `spi_cfg_port`

## Requirements
- R1: The first byte of each transfer is the instruction, sent MSB first. Bit 7 = 1 means read and 0 means write. Bits [ADDR_W-1:0] give the register address. Bits 6 down to ADDR_W are ignored.
- R2: Write data is shifted in MSB first and sampled on rising serial clock edges. A byte is stored only once all 8 of its bits have arrived. A byte cut short by select going high leaves the register unchanged.
- R3: After each data byte, read or write, the address steps up by one and wraps from 2^ADDR_W-1 to 0.
- R4: Read data leaves MSB first. The output bit changes only after a falling serial clock edge, so each bit is steady at the following rising edge.
- R5: When register 0 bit 7 is 0, read data appears on `sdio_o` with `sdio_oe` high, and `sdo_oe` stays low.
- R6: When register 0 bit 7 is 1, read data appears on `sdo_o` with `sdo_oe` high, and `sdio_oe` stays low. The two enables are never high together.
- R7: An output enable is high only during a read data phase with select low. Raising select turns both enables off and returns the port to the instruction phase.
- R8: A high level on `sync_i` ends the current transfer and turns the enables off. Register contents do not change. A new instruction can then start within the same select-low period.
- R9: After reset, all registers read 0, both enables are low, and both data outputs are 0.
- R10: `rf_rdata_o` shows the register addressed by `rf_raddr_i` one clock cycle after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csb_i | input | 1 | Serial select, active low |
| sck_i | input | 1 | Serial clock from the host |
| sdio_i | input | 1 | Input side of the bidirectional data pin |
| sync_i | input | 1 | Transfer abort, active high |
| rf_raddr_i | input | ADDR_W | Core-side register read address |
| sdio_o | output | 1 | Output side of the bidirectional data pin |
| sdio_oe | output | 1 | Drive enable for the bidirectional data pin |
| sdo_o | output | 1 | Separate serial read-data output |
| sdo_oe | output | 1 | Drive enable for the separate output |
| rf_rdata_o | output | 8 | Core-side register read data |

## Verification
Single-byte and three-byte write and read frames are used, and the three-byte frame starts near the top of the address space. This shows whether the address steps and wraps, and whether each byte lands in its own register. Frames are also broken off after part of a byte, either by raising select or by a sync pulse that is followed by a fresh instruction in the same select period. These frames separate correct commit timing from early storage. Reads are repeated with the pin-mode bit set and then cleared, so that a swapped or doubled output enable shows up. An instruction with its unused middle bits set shows whether those bits are masked from the address.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int unsigned BYTE_BITS = 8;
  localparam int unsigned CNT_W     = $clog2(BYTE_BITS);
  localparam int unsigned MODE_REG  = 0;
  localparam int unsigned MODE_BIT  = 7;

  typedef enum logic {
    PH_INSTR = 1'b0,
    PH_DATA  = 1'b1
  } phase_e;
endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] INIT  = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= INIT;
          else     stage_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= INIT;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_cfg_fsm.sv
module spi_cfg_fsm
  import spi_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cs_act_i,
  input  logic                 sck_i,
  input  logic                 sd_i,
  input  logic                 abort_i,
  output logic                 we_o,
  output logic [ADDR_W-1:0]    waddr_o,
  output logic [BYTE_BITS-1:0] wdata_o,
  output logic                 rd_en_o,
  output logic [ADDR_W-1:0]    raddr_o,
  output logic                 rd_active_o,
  output logic                 fall_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS - 1);

  phase_e                 phase_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [BYTE_BITS-2:0]   sh_q;
  logic                   rw_q;
  logic [ADDR_W-1:0]      addr_q;
  logic                   sck_p_q;

  logic                   rise;
  logic                   live;
  logic                   byte_end;
  logic [BYTE_BITS-1:0]   byte_now;

  assign rise     = sck_i & ~sck_p_q;
  assign fall_o   = ~sck_i & sck_p_q;
  assign live     = cs_act_i & ~abort_i;
  assign byte_now = {sh_q, sd_i};
  assign byte_end = live & rise & (cnt_q == LAST_BIT);

  always_ff @(posedge clk) begin
    if (rst) sck_p_q <= 1'b0;
    else     sck_p_q <= sck_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_INSTR;
      cnt_q   <= '0;
      sh_q    <= '0;
      rw_q    <= 1'b0;
      addr_q  <= '0;
    end else if (!live) begin
      phase_q <= PH_INSTR;
      cnt_q   <= '0;
      rw_q    <= 1'b0;
    end else if (rise) begin
      sh_q  <= byte_now[BYTE_BITS-2:0];
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST_BIT) begin
        if (phase_q == PH_INSTR) begin
          phase_q <= PH_DATA;
          rw_q    <= byte_now[BYTE_BITS-1];
          addr_q  <= byte_now[ADDR_W-1:0];
        end else begin
          addr_q  <= addr_q + 1'b1;
        end
      end
    end
  end

  always_comb begin
    we_o    = byte_end & (phase_q == PH_DATA) & ~rw_q;
    waddr_o = addr_q;
    wdata_o = byte_now;
    if (phase_q == PH_INSTR) begin
      rd_en_o = byte_end & byte_now[BYTE_BITS-1];
      raddr_o = byte_now[ADDR_W-1:0];
    end else begin
      rd_en_o = byte_end & rw_q;
      raddr_o = addr_q + 1'b1;
    end
  end

  assign rd_active_o = (phase_q == PH_DATA) & rw_q;
endmodule

// File: rtl/spi_cfg_regfile.sv
module spi_cfg_regfile
  import spi_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    waddr_i,
  input  logic [BYTE_BITS-1:0] wdata_i,
  input  logic                 rd_en_i,
  input  logic [ADDR_W-1:0]    raddr_i,
  output logic [BYTE_BITS-1:0] rdata_o,
  input  logic [ADDR_W-1:0]    core_raddr_i,
  output logic [BYTE_BITS-1:0] core_rdata_o,
  output logic                 mode4_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [BYTE_BITS-1:0] regs_q [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)
          regs_q[i] <= '0;
        else if (we_i && (waddr_i == ADDR_W'(i)))
          regs_q[i] <= wdata_i;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)          rdata_o <= '0;
    else if (rd_en_i) rdata_o <= regs_q[raddr_i];
  end

  always_ff @(posedge clk) begin
    if (rst) core_rdata_o <= '0;
    else     core_rdata_o <= regs_q[core_raddr_i];
  end

  assign mode4_o = regs_q[MODE_REG][MODE_BIT];
endmodule

// File: rtl/spi_cfg_txpath.sv
module spi_cfg_txpath
  import spi_cfg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en_i,
  input  logic [BYTE_BITS-1:0] rdata_i,
  input  logic                 fall_i,
  input  logic                 rd_active_i,
  input  logic                 cs_act_i,
  input  logic                 abort_i,
  input  logic                 mode4_i,
  output logic                 sdio_o,
  output logic                 sdio_oe,
  output logic                 sdo_o,
  output logic                 sdo_oe
);
  logic                 load_q;
  logic [BYTE_BITS-1:0] tx_q;
  logic                 bit_q;
  logic                 drive;

  assign drive = rd_active_i & cs_act_i & ~abort_i;

  always_ff @(posedge clk) begin
    if (rst) load_q <= 1'b0;
    else     load_q <= rd_en_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q  <= '0;
      bit_q <= 1'b0;
    end else if (load_q) begin
      tx_q  <= rdata_i;
    end else if (fall_i && drive) begin
      bit_q <= tx_q[BYTE_BITS-1];
      tx_q  <= {tx_q[BYTE_BITS-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sdio_oe <= 1'b0;
      sdo_oe  <= 1'b0;
    end else begin
      sdio_oe <= drive & ~mode4_i;
      sdo_oe  <= drive &  mode4_i;
    end
  end

  assign sdio_o = bit_q;
  assign sdo_o  = bit_q;
endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
  import spi_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 csb_i,
  input  logic                 sck_i,
  input  logic                 sdio_i,
  input  logic                 sync_i,
  input  logic [ADDR_W-1:0]    rf_raddr_i,
  output logic                 sdio_o,
  output logic                 sdio_oe,
  output logic                 sdo_o,
  output logic                 sdo_oe,
  output logic [BYTE_BITS-1:0] rf_rdata_o
);
  localparam int unsigned   NIN     = 4;
  localparam logic [NIN-1:0] IN_IDLE = 4'b1000;

  logic [NIN-1:0]       pins_s;
  logic                 csb_s, sck_s, sd_s, abort_s;
  logic                 cs_act;
  logic                 wr_en, rd_en, rd_active, sck_fall, pin_mode4;
  logic [ADDR_W-1:0]    waddr, raddr;
  logic [BYTE_BITS-1:0] wdata, ser_rdata;

  spi_cfg_sync #(.W(NIN), .STAGES(SYNC_STAGES), .INIT(IN_IDLE)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({csb_i, sck_i, sdio_i, sync_i}),
    .q_o (pins_s)
  );

  assign {csb_s, sck_s, sd_s, abort_s} = pins_s;
  assign cs_act = ~csb_s;

  spi_cfg_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .cs_act_i    (cs_act),
    .sck_i       (sck_s),
    .sd_i        (sd_s),
    .abort_i     (abort_s),
    .we_o        (wr_en),
    .waddr_o     (waddr),
    .wdata_o     (wdata),
    .rd_en_o     (rd_en),
    .raddr_o     (raddr),
    .rd_active_o (rd_active),
    .fall_o      (sck_fall)
  );

  spi_cfg_regfile #(.ADDR_W(ADDR_W)) u_rf (
    .clk          (clk),
    .rst          (rst),
    .we_i         (wr_en),
    .waddr_i      (waddr),
    .wdata_i      (wdata),
    .rd_en_i      (rd_en),
    .raddr_i      (raddr),
    .rdata_o      (ser_rdata),
    .core_raddr_i (rf_raddr_i),
    .core_rdata_o (rf_rdata_o),
    .mode4_o      (pin_mode4)
  );

  spi_cfg_txpath u_tx (
    .clk         (clk),
    .rst         (rst),
    .rd_en_i     (rd_en),
    .rdata_i     (ser_rdata),
    .fall_i      (sck_fall),
    .rd_active_i (rd_active),
    .cs_act_i    (cs_act),
    .abort_i     (abort_s),
    .mode4_i     (pin_mode4),
    .sdio_o      (sdio_o),
    .sdio_oe     (sdio_oe),
    .sdo_o       (sdo_o),
    .sdo_oe      (sdo_oe)
  );
endmodule

// File: rtl/spi_cfg_chk.sv
module spi_cfg_chk #(
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              csb_i,
  input logic              sdio_o,
  input logic              sdio_oe,
  input logic              sdo_oe,
  input logic              sck_fall,
  input logic              abort_s,
  input logic              wr_en,
  input logic [ADDR_W-1:0] waddr,
  input logic              pin_mode4
);
  // R6: only one pin is ever driven
  a_r6_single_driver: assert property (@(posedge clk) disable iff (rst)
    !(sdio_oe && sdo_oe));

  // R7: an enable needs select low three cycles earlier (two sync stages plus one register)
  a_r7_oe_needs_cs: assert property (@(posedge clk) disable iff (rst)
    (sdio_oe || sdo_oe) |-> !$past(csb_i, 3));

  // R8: abort turns both enables off and blocks any register write
  a_r8_abort_quiet: assert property (@(posedge clk) disable iff (rst)
    abort_s |=> (!sdio_oe && !sdo_oe && !wr_en));

  // R4: the read bit moves only after a falling serial clock edge
  a_r4_out_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdio_o) |-> $past(sck_fall));

  // R6: the pin-mode bit changes only through a write to register 0
  a_r6_mode_by_write: assert property (@(posedge clk) disable iff (rst)
    !$stable(pin_mode4) |-> $past(wr_en && (waddr == '0)));
endmodule

bind spi_cfg_port spi_cfg_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .csb_i     (csb_i),
  .sdio_o    (sdio_o),
  .sdio_oe   (sdio_oe),
  .sdo_oe    (sdo_oe),
  .sck_fall  (sck_fall),
  .abort_s   (abort_s),
  .wr_en     (wr_en),
  .waddr     (waddr),
  .pin_mode4 (pin_mode4)
);

// File: tb/sim_spi_cfg_port.sv
module sim_spi_cfg_port;
  localparam int CLK_P  = 10;
  localparam int HALF   = 8;
  localparam int ADDR_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csb_i = 1'b1, sck_i = 1'b0, sdio_i = 1'b0, sync_i = 1'b0;
  logic [ADDR_W-1:0] rf_raddr_i = '0;
  logic sdio_o, sdio_oe, sdo_o, sdo_oe;
  logic [7:0] rf_rdata_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int    exp_q[$];
  string tag_q[$];
  int    rx_q[$];

  always #(CLK_P/2) clk = ~clk;

  spi_cfg_port #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst(rst), .csb_i(csb_i), .sck_i(sck_i), .sdio_i(sdio_i),
    .sync_i(sync_i), .rf_raddr_i(rf_raddr_i), .sdio_o(sdio_o),
    .sdio_oe(sdio_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe), .rf_rdata_o(rf_rdata_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbit(input logic b, input bit use_sdo, output logic got, output bit oe_ok);
    sdio_i = b;
    wait_n(HALF);
    got   = use_sdo ? sdo_o : sdio_o;
    oe_ok = use_sdo ? (sdo_oe && !sdio_oe) : (sdio_oe && !sdo_oe);
    sck_i = 1'b1;
    wait_n(HALF);
    sck_i = 1'b0;
  endtask

  task automatic xbyte(input logic [7:0] tx, input bit use_sdo,
                       output logic [7:0] rx, output int oe_bad);
    logic g;
    bit   ok;
    oe_bad = 0;
    for (int i = 7; i >= 0; i--) begin
      xbit(tx[i], use_sdo, g, ok);
      rx[i] = g;
      if (!ok) oe_bad++;
    end
  endtask

  task automatic open_frame();
    csb_i = 1'b0;
    wait_n(HALF);
  endtask

  task automatic close_frame();
    wait_n(HALF);
    csb_i = 1'b1;
    wait_n(4*HALF);
  endtask

  task automatic write_frame(input logic [7:0] instr, input int n,
                             input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
    logic [7:0] r;
    int b;
    logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    open_frame();
    xbyte(instr, 1'b0, r, b);
    for (int i = 0; i < n; i++) xbyte(d[i], 1'b0, r, b);
    close_frame();
  endtask

  task automatic expect_byte(input int v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic read_frame(input logic [ADDR_W-1:0] a, input int n,
                            input bit use_sdo, input string pin_tag);
    logic [7:0] r;
    int b;
    open_frame();
    xbyte({3'b100, a}, use_sdo, r, b);
    for (int i = 0; i < n; i++) begin
      xbyte(8'h00, use_sdo, r, b);
      rx_q.push_back(int'(r));
      chk(b == 0, pin_tag, b, 0);
    end
    close_frame();
  endtask

  task automatic core_rd(input logic [ADDR_W-1:0] a, input int exp, input string tag);
    rf_raddr_i = a;
    @(negedge clk);
    chk(rf_rdata_o == exp[7:0], tag, rf_rdata_o, exp);
  endtask

  // scoreboard monitor
  initial begin
    int got, e;
    string t;
    forever begin
      wait (rx_q.size() > 0);
      got = rx_q.pop_front();
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected byte", got, 0);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(got == e, t, got, e);
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int b;
    @(negedge clk);
    wait_n(5);
    rst = 1'b0;
    wait_n(3);

    // R9 reset state
    chk(!sdio_oe && !sdo_oe, "R9 enables", {sdio_oe, sdo_oe}, 0);
    chk(!sdio_o && !sdo_o, "R9 data outs", {sdio_o, sdo_o}, 0);
    core_rd(5'd0, 0, "R9 reg0");
    core_rd(5'd31, 0, "R9 reg31");

    // R2 single write, R10 core read
    write_frame(8'h03, 1, 8'hA5, 8'h00, 8'h00);
    core_rd(5'd3, 8'hA5, "R2 R10 reg3");

    // R3 multi-byte write with wrap
    write_frame(8'h1E, 3, 8'h11, 8'h22, 8'h33);
    core_rd(5'd30, 8'h11, "R3 reg30");
    core_rd(5'd31, 8'h22, "R3 reg31");
    core_rd(5'd0, 8'h33, "R3 wrap reg0");

    // R1 unused instruction bits ignored
    write_frame(8'h65, 1, 8'h6E, 8'h00, 8'h00);
    core_rd(5'd5, 8'h6E, "R1 masked address");

    // R2 partial byte not committed; R7 no drive during write
    open_frame();
    xbyte(8'h03, 1'b0, r, b);
    for (int i = 0; i < 5; i++) begin
      logic g; bit ok;
      xbit(1'b1, 1'b0, g, ok);
    end
    chk(!sdio_oe && !sdo_oe, "R7 no drive in write", {sdio_oe, sdo_oe}, 0);
    close_frame();
    core_rd(5'd3, 8'hA5, "R2 partial byte");

    // R8 abort mid-byte, then fresh instruction in same frame
    open_frame();
    xbyte(8'h03, 1'b0, r, b);
    for (int i = 0; i < 4; i++) begin
      logic g; bit ok;
      xbit(1'b0, 1'b0, g, ok);
    end
    sync_i = 1'b1;
    wait_n(4);
    sync_i = 1'b0;
    wait_n(HALF);
    xbyte(8'h07, 1'b0, r, b);
    xbyte(8'h5C, 1'b0, r, b);
    close_frame();
    core_rd(5'd3, 8'hA5, "R8 reg kept");
    core_rd(5'd7, 8'h5C, "R8 restart");

    // R4 R5 reads on the bidirectional pin
    expect_byte(8'hA5, "R4 read reg3");
    read_frame(5'd3, 1, 1'b0, "R5 sdio enable");
    expect_byte(8'h11, "R3 read reg30");
    expect_byte(8'h22, "R3 read reg31");
    expect_byte(8'h33, "R3 read wrap");
    read_frame(5'd30, 3, 1'b0, "R5 sdio enable");
    expect_byte(8'h6E, "R4 read reg5");
    read_frame(5'd5, 1, 1'b0, "R5 sdio enable");

    // R8 abort during read phase
    open_frame();
    xbyte(8'h83, 1'b0, r, b);
    for (int i = 0; i < 3; i++) begin
      logic g; bit ok;
      xbit(1'b0, 1'b0, g, ok);
    end
    chk(sdio_oe, "R8 driving before abort", sdio_oe, 1);
    sync_i = 1'b1;
    wait_n(6);
    chk(!sdio_oe && !sdo_oe, "R8 abort releases pin", {sdio_oe, sdo_oe}, 0);
    sync_i = 1'b0;
    close_frame();

    // R7 select high mid-read
    open_frame();
    xbyte(8'h9E, 1'b0, r, b);
    for (int i = 0; i < 2; i++) begin
      logic g; bit ok;
      xbit(1'b0, 1'b0, g, ok);
    end
    csb_i = 1'b1;
    wait_n(6);
    chk(!sdio_oe && !sdo_oe, "R7 select high releases", {sdio_oe, sdo_oe}, 0);
    wait_n(4*HALF);
    expect_byte(8'h5C, "R7 instruction phase after select");
    read_frame(5'd7, 1, 1'b0, "R5 sdio enable");

    // R6 four-wire mode
    write_frame(8'h00, 1, 8'h80, 8'h00, 8'h00);
    expect_byte(8'h80, "R6 read reg0");
    read_frame(5'd0, 1, 1'b1, "R6 sdo enable");
    expect_byte(8'hA5, "R6 read reg3");
    read_frame(5'd3, 1, 1'b1, "R6 sdo enable");

    // back to three-wire
    write_frame(8'h00, 1, 8'h00, 8'h00, 8'h00);
    core_rd(5'd0, 0, "R6 mode cleared");
    expect_byte(8'h5C, "R5 read reg7");
    read_frame(5'd7, 1, 1'b0, "R5 sdio enable");

    wait_n(20);
    chk(exp_q.size() == 0, "R4 all bytes seen", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule